// File: doc/BRIEF.md
# Platform-Level Interrupt Router

This block gathers a set of external interrupt sources and routes them to several hart contexts. A context is one privilege mode of one hardware thread. Each source passes through a gateway, which is level-sensitive or edge-sensitive as set per source by a parameter. The gateway sets a pending bit and keeps it set until a context claims the source. Each context has its own enable mask and its own priority threshold. Each context drives one interrupt line, which is high whenever at least one source is pending, enabled for that context, and has a priority strictly above that context's threshold.

Software sets priorities, enables and thresholds through simple write strobes. A handler raises its context's claim strobe for one cycle. The next cycle, it reads the winning source ID from the claim result. That source then stays in service, and its gateway takes no new requests, until a completion strobe carries its ID. Source ID 0 means "no interrupt". Context slots can be marked absent with a parameter. An absent context never raises its line and always claims 0.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable bit and threshold is 0, nothing is pending or in service, every `irq_out` bit is 0 and every claim result is 0.
- R2: A source reaches a context only if that context's enable bit for the source is 1. One source may be enabled in several contexts at once.
- R3: A pending, enabled source is eligible for a context only if its priority is strictly greater than the context's threshold. Priority 0 never interrupts, and a priority equal to the threshold is masked.
- R4: A claim returns the eligible source with the highest priority, and the lowest ID wins a tie. The result appears on `claim_id` in the cycle after the claim strobe and is held until that context's next claim.
- R5: A claim that finds no eligible source returns 0 and changes no pending or in-service state.
- R6: A claim clears the pending bit at the same clock edge. When several contexts claim the same source in one cycle, the lowest-numbered context receives the ID and the others receive 0.
- R7: While a source is in service, its gateway sets no pending bit. Only a completion carrying that source's ID ends service; a completion with any other ID has no effect.
- R8: A level source (`EDGE_MASK` bit 0; source ID n is `src_in[n-1]`) latches pending while the input is high, and stays pending if the input falls before a claim. At the completion edge, pending is set again if the input is still high.
- R9: An edge source (`EDGE_MASK` bit 1) becomes pending on a rising edge. Any number of rising edges during service are remembered as one request, which becomes pending at the completion edge.
- R10: A context whose `CTX_PRESENT` bit is 0 never asserts its `irq_out` bit and always claims 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Source requests; bit n-1 is source ID n |
| prio_we | input | 1 | Priority write strobe |
| prio_src | input | ID_W | Source ID written by the priority strobe |
| prio_val | input | PRIO_W | Priority value |
| en_we | input | 1 | Enable write strobe |
| en_ctx | input | CTX_W | Context written by the enable strobe |
| en_src | input | ID_W | Source ID written by the enable strobe |
| en_val | input | 1 | Enable bit value |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context written by the threshold strobe |
| thr_val | input | PRIO_W | Threshold value |
| claim_req | input | NCTX | Per-context claim strobe |
| cpl_we | input | 1 | Completion strobe |
| cpl_id | input | ID_W | Source ID being completed |
| irq_out | output | NCTX | Per-context interrupt line |
| claim_id | output | NCTX*ID_W | Claim results; context c at bits c*ID_W upward |

## Verification
`irq_out` is combinational from registered state. It reflects a configuration write, a claim or a completion right after the clock edge that takes the strobe, and a level request after the edge that samples the input. `claim_id` is registered: it changes at the edge that takes the claim strobe. The bench drives every input and samples every output 2 ns after a rising edge, one edge after each stimulus. This gives exactly one register stage between a stimulus and the check that reads its result. The latched-level, remembered-edge and simultaneous-claim cases each get a directed sequence that checks the line both before and after the completion edge.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 8,
  parameter int NCTX = 3,
  parameter int PRIO_W = 3,
  parameter logic [NSRC-1:0] EDGE_MASK = 8'hF0,
  parameter logic [NCTX-1:0] CTX_PRESENT = 3'b011,
  localparam int ID_W = $clog2(NSRC + 1),
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_in,
  input  logic                 prio_we,
  input  logic [ID_W-1:0]      prio_src,
  input  logic [PRIO_W-1:0]    prio_val,
  input  logic                 en_we,
  input  logic [CTX_W-1:0]     en_ctx,
  input  logic [ID_W-1:0]      en_src,
  input  logic                 en_val,
  input  logic                 thr_we,
  input  logic [CTX_W-1:0]     thr_ctx,
  input  logic [PRIO_W-1:0]    thr_val,
  input  logic [NCTX-1:0]      claim_req,
  input  logic                 cpl_we,
  input  logic [ID_W-1:0]      cpl_id,
  output logic [NCTX-1:0]      irq_out,
  output logic [NCTX*ID_W-1:0] claim_id
);

  logic [PRIO_W-1:0] prio [1:NSRC];
  logic [NSRC:1]     en [NCTX];
  logic [PRIO_W-1:0] thr [NCTX];
  logic [NSRC:1]     pend, busy, held, prev;
  logic [NSRC:1]     rise, trig, clm, cpl_hit;
  logic [ID_W-1:0]   best_id [NCTX];
  logic [PRIO_W-1:0] best_pr [NCTX];
  logic [ID_W-1:0]   grant [NCTX];
  logic [ID_W-1:0]   claim_q [NCTX];

  assign rise = src_in & ~prev;
  assign trig = (EDGE_MASK & rise) | (~EDGE_MASK & src_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      if (prio_we && prio_src != '0 && int'(prio_src) <= NSRC)
        prio[prio_src] <= prio_val;
      if (en_we && int'(en_ctx) < NCTX && en_src != '0 && int'(en_src) <= NSRC)
        en[en_ctx][en_src] <= en_val;
      if (thr_we && int'(thr_ctx) < NCTX)
        thr[thr_ctx] <= thr_val;
    end
  end

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_pr[c] = thr[c];
      for (int s = 1; s <= NSRC; s++)
        if (pend[s] && en[c][s] && prio[s] > best_pr[c]) begin
          best_pr[c] = prio[s];
          best_id[c] = ID_W'(s);
        end
      if (!CTX_PRESENT[c]) best_id[c] = '0;
    end
  end

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      grant[c] = claim_req[c] ? best_id[c] : '0;
      for (int k = 0; k < c; k++)
        if (claim_req[k] && best_id[k] == best_id[c]) grant[c] = '0;
    end
  end

  always_comb begin
    clm = '0;
    for (int c = 0; c < NCTX; c++)
      for (int s = 1; s <= NSRC; s++)
        if (grant[c] == ID_W'(s)) clm[s] = 1'b1;
  end

  always_comb begin
    for (int s = 1; s <= NSRC; s++)
      cpl_hit[s] = cpl_we && cpl_id == ID_W'(s) && busy[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      busy <= '0;
      held <= '0;
      prev <= '0;
    end else begin
      prev <= src_in;
      for (int s = 1; s <= NSRC; s++) begin
        if (clm[s]) begin
          pend[s] <= 1'b0;
          busy[s] <= 1'b1;
        end else if (cpl_hit[s]) begin
          busy[s] <= 1'b0;
          held[s] <= 1'b0;
          pend[s] <= EDGE_MASK[s-1] ? (held[s] | rise[s]) : src_in[s-1];
        end else if (!busy[s]) begin
          if (trig[s]) pend[s] <= 1'b1;
        end else if (rise[s] && EDGE_MASK[s-1]) begin
          held[s] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTX; c++) claim_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCTX; c++)
        if (claim_req[c]) claim_q[c] <= grant[c];
    end
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_out
    assign irq_out[c] = best_id[c] != '0;
    assign claim_id[c*ID_W +: ID_W] = claim_q[c];
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC = 8,
  parameter int NCTX = 3,
  parameter int ID_W = 4,
  parameter logic [NSRC-1:0] EDGE_MASK = 8'hF0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      src_in,
  input logic [NCTX-1:0]      claim_req,
  input logic                 cpl_we,
  input logic [ID_W-1:0]      cpl_id,
  input logic [NCTX-1:0]      irq_out,
  input logic [NCTX*ID_W-1:0] claim_id,
  input logic [NSRC:1]        pend,
  input logic [NSRC:1]        busy
);

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    a_r5_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_req[c] && !irq_out[c]) |=> claim_id[c*ID_W +: ID_W] == '0);
    for (genvar d = c + 1; d < NCTX; d++) begin : g_pair
      a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_req[c] && claim_req[d]) |=>
          (claim_id[d*ID_W +: ID_W] == '0 ||
           claim_id[d*ID_W +: ID_W] != claim_id[c*ID_W +: ID_W]));
    end
  end

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    a_r6_service_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[s]) |-> $past(|claim_req));
    a_r7_hold_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[s] && !(cpl_we && cpl_id == ID_W'(s))) |=> busy[s]);
    if (!EDGE_MASK[s-1]) begin : g_lvl
      a_r8_level_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_we && cpl_id == ID_W'(s) && busy[s] && src_in[s-1]) |=> pend[s]);
    end
  end

endmodule

bind irq_router irq_router_chk #(
  .NSRC(NSRC), .NCTX(NCTX), .ID_W(ID_W), .EDGE_MASK(EDGE_MASK)
) u_chk (.*);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int NSRC = 8, NCTX = 3, PRIO_W = 3, ID_W = 4, CTX_W = 2;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_in = '0;
  logic prio_we = 0, en_we = 0, thr_we = 0, en_val = 0, cpl_we = 0;
  logic [ID_W-1:0] prio_src = '0, en_src = '0, cpl_id = '0;
  logic [PRIO_W-1:0] prio_val = '0, thr_val = '0;
  logic [CTX_W-1:0] en_ctx = '0, thr_ctx = '0;
  logic [NCTX-1:0] claim_req = '0;
  logic [NCTX-1:0] irq_out;
  logic [NCTX*ID_W-1:0] claim_id;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router dut (.*);

  // {prio, thr, expected line}: source 2 held high, enabled on context 0
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 3'd0, 1'b0}, {3'd1, 3'd0, 1'b1}, {3'd3, 3'd3, 1'b0}, {3'd4, 3'd3, 1'b1},
    {3'd7, 3'd6, 1'b1}, {3'd7, 3'd7, 1'b0}, {3'd2, 3'd5, 1'b0}, {3'd5, 3'd1, 1'b1}};

  task automatic step(); @(posedge clk); #2; endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cid(int c); return int'(claim_id[c*ID_W +: ID_W]); endfunction

  task automatic do_reset();
    src_in = '0; claim_req = '0; cpl_we = 0; prio_we = 0; en_we = 0; thr_we = 0;
    rst_n = 0; step(); rst_n = 1; step();
  endtask

  task automatic wr_prio(int id, int p);
    prio_we = 1; prio_src = ID_W'(id); prio_val = PRIO_W'(p); step(); prio_we = 0;
  endtask
  task automatic wr_en(int c, int id, bit v);
    en_we = 1; en_ctx = CTX_W'(c); en_src = ID_W'(id); en_val = v; step(); en_we = 0;
  endtask
  task automatic wr_thr(int c, int t);
    thr_we = 1; thr_ctx = CTX_W'(c); thr_val = PRIO_W'(t); step(); thr_we = 0;
  endtask
  task automatic claim(logic [NCTX-1:0] m); claim_req = m; step(); claim_req = '0; endtask
  task automatic complete(int id); cpl_we = 1; cpl_id = ID_W'(id); step(); cpl_we = 0; endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 claim_id", int'(claim_id), 0);
    src_in = 8'hFF; step();
    chk("R1 zero priorities mask all", int'(irq_out), 0);
    claim(3'b001);
    chk("R5 empty claim", cid(0), 0);

    do_reset();
    wr_en(0, 2, 1);
    src_in[1] = 1;
    for (int i = 0; i < 8; i++) begin
      wr_prio(2, int'(VEC[i][6:4]));
      wr_thr(0, int'(VEC[i][3:1]));
      chk("R3 threshold gate", int'(irq_out[0]), int'(VEC[i][0]));
    end

    do_reset();
    wr_prio(1, 2); wr_prio(3, 5); wr_prio(4, 5);
    wr_en(0, 1, 1); wr_en(0, 3, 1); wr_en(0, 4, 1);
    src_in[0] = 1; src_in[2] = 1; src_in[3] = 1; step();
    chk("R4 line up", int'(irq_out[0]), 1);
    claim(3'b001); chk("R4 tie lowest id", cid(0), 3);
    claim(3'b001); chk("R4 next same prio", cid(0), 4);
    claim(3'b001); chk("R4 lowest prio last", cid(0), 1);
    chk("R7 in service no repend", int'(irq_out[0]), 0);
    claim(3'b001); chk("R5 nothing left", cid(0), 0);
    complete(2); step();
    chk("R7 foreign completion", int'(irq_out[0]), 0);
    complete(3);
    chk("R8 level rearm", int'(irq_out[0]), 1);
    claim(3'b001); chk("R8 reclaim", cid(0), 3);

    do_reset();
    wr_prio(2, 1); wr_en(0, 2, 1);
    src_in[1] = 1; step(); src_in[1] = 0; step();
    chk("R8 latched after drop", int'(irq_out[0]), 1);
    claim(3'b001); chk("R8 claim latched", cid(0), 2);
    complete(2); step();
    chk("R8 no rearm when low", int'(irq_out[0]), 0);

    do_reset();
    wr_prio(1, 3); wr_en(1, 1, 1);
    src_in[0] = 1; step();
    chk("R2 disabled ctx quiet", int'(irq_out[0]), 0);
    chk("R2 enabled ctx line", int'(irq_out[1]), 1);
    claim(3'b001); chk("R2 disabled ctx claims 0", cid(0), 0);
    claim(3'b010); chk("R2 enabled ctx claims", cid(1), 1);

    do_reset();
    wr_prio(1, 3); wr_en(0, 1, 1); wr_en(1, 1, 1);
    src_in[0] = 1; step();
    claim(3'b011);
    chk("R6 low ctx wins", cid(0), 1);
    chk("R6 other ctx gets 0", cid(1), 0);
    chk("R6 pending cleared", int'(irq_out[1:0]), 0);

    do_reset();
    wr_prio(6, 2); wr_en(0, 6, 1);
    src_in[5] = 1; step(); src_in[5] = 0; step();
    chk("R9 edge pending", int'(irq_out[0]), 1);
    claim(3'b001); chk("R9 edge claim", cid(0), 6);
    src_in[5] = 1; step(); src_in[5] = 0; step(); src_in[5] = 1; step(); src_in[5] = 0; step();
    chk("R9 quiet in service", int'(irq_out[0]), 0);
    complete(6);
    chk("R9 remembered edge", int'(irq_out[0]), 1);
    claim(3'b001); complete(6);
    chk("R9 edges collapse to one", int'(irq_out[0]), 0);

    do_reset();
    wr_prio(1, 3); wr_en(2, 1, 1);
    src_in[0] = 1; step();
    chk("R10 absent ctx line", int'(irq_out[2]), 0);
    claim(3'b100); chk("R10 absent ctx claim", cid(2), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule